// File: doc/BRIEF.md
# ATM Cell Ingress Buffer

This block sits between an ATM-layer device and a framer. The ATM-layer device pushes 53-byte cells into it over a transmit bus: an active-low write strobe, a 16-bit data bus and a start-of-cell marker. The block collects each cell into an internal byte store that holds a whole number of cells. A mode pin, sampled only during reset, selects either a wide bus that carries two bytes per write or a narrow bus that carries one byte per write on the low lane.

A cell-available flag tells the sender whether it may start another cell. The flag is raised when a complete cell fits and dropped early, while only four write cycles of room are left, so a sender that reacts late still does not overrun. Cells go out one byte at a time on a valid/ready handshake, and a cell becomes visible only after all 53 of its bytes are stored. A first-byte marker travels with each cell. Writes that find the store full are thrown away, the cell they belong to is discarded as a whole, and a sticky overflow flag records the event.

Top module: `cell_ingress_fifo`

## Requirements
- R1: `wide_mode` is latched only while `rst_n` is low. Wide mode (1) stores `wr_data[7:0]` first and `wr_data[15:8]` second. Narrow mode (0) stores only `wr_data[7:0]`. Changes on `wide_mode` after reset have no effect.
- R2: A write is taken on a rising clock edge only when `wr_en_n` is low. Data and `wr_soc` seen while `wr_en_n` is high have no effect.
- R3: Writes taken while no cell is open are dropped unless `wr_soc` is high. A write with `wr_soc` high opens a cell, and its data are the first byte or bytes of that cell.
- R4: While a cell is open, `wr_soc` is ignored until that cell's 53rd byte has been taken.
- R5: In wide mode a cell takes 27 writes. The 27th write stores only `wr_data[7:0]` as byte 53, and `wr_data[15:8]` is discarded.
- R6: `rd_valid` rises only once all 53 bytes of a cell are stored. Bytes leave in arrival order, one per cycle in which `rd_valid` and `rd_ready` are both high. `rd_sop` is high on the first byte of each cell. `rd_data` and `rd_valid` hold while `rd_ready` is low.
- R7: `cell_avail` is high in the cycle after the store has at least 53 free bytes.
- R8: `cell_avail` is low in the cycle after the free space is at most 4 bytes (narrow mode) or 8 bytes (wide mode). Between the two thresholds it keeps its value.
- R9: A byte that finds the store full is discarded and `overflow` is set and stays set until reset. The cell that lost the byte is never presented at the output.
- R10: During reset `rd_valid`, `cell_avail` and `overflow` are low.
- R11: The store holds two complete cells. Two back-to-back cells with no reads cause no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wide_mode | input | 1 | 1 = two bytes per write, 0 = one byte; latched during reset |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_data | input | 16 | Write data, bit 0 least significant |
| wr_soc | input | 1 | Marks the first write of a cell |
| cell_avail | output | 1 | Room for a further cell |
| overflow | output | 1 | Sticky: a byte was lost to a full store |
| rd_ready | input | 1 | Reader accepts the presented byte |
| rd_valid | output | 1 | A stored byte is presented |
| rd_data | output | 8 | Presented byte |
| rd_sop | output | 1 | Presented byte is the first of its cell |

## Verification
The hardest state to reach is a cell that is already partly stored when the store runs out of room. That cell must vanish while the complete cells ahead of it survive, and `cell_avail` must move through its hysteresis band both downwards and upwards. The directed part holds `rd_ready` low across two full cells and then starts a third, in both bus modes, and afterwards drains the store. The random part alternates long windows of stalled reads with free-running reads, so that partial cells are aborted at many different fill levels. It also toggles the mode pin, inserts stray start markers, and sends writes before any start marker.

// File: rtl/cif_pkg.sv
// Package: shared types for the cell ingress buffer.
// Assumes a fixed 16-bit write bus carrying at most two bytes per write.
package cif_pkg;

    typedef enum logic {
        BUS_NARROW = 1'b0,
        BUS_WIDE   = 1'b1
    } bus_mode_e;

    // Bytes that one accepted write contributes to the open cell.
    typedef struct packed {
        logic [1:0]  vld;    // bit0: low lane byte, bit1: high lane byte
        logic [15:0] bytes;  // [7:0] earlier byte, [15:8] later byte
        logic        last;   // this write completes the cell
    } lane_write_t;

endpackage

// File: rtl/cif_cell_assembler.sv
// Module: cif_cell_assembler
// Tracks cell framing on the write bus. It opens a cell on an accepted
// write with the start marker, counts bytes up to CELL_BYTES, ignores
// markers inside a cell, and drops writes outside any cell.
// Assumes the mode is constant outside reset.
module cif_cell_assembler
    import cif_pkg::*;
#(
    parameter int unsigned CELL_BYTES = 53
) (
    input  logic        clk,
    input  logic        rst_n,
    input  bus_mode_e   mode,
    input  logic        wr_en_n,
    input  logic [15:0] wr_data,
    input  logic        wr_soc,
    output lane_write_t lw
);
    localparam int unsigned CNT_W = $clog2(CELL_BYTES + 1);

    logic             in_cell_q;
    logic [CNT_W-1:0] cnt_q;
    logic             starting;
    logic             active;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] next_cnt;

    // Decide how many bytes of this write belong to the open cell.
    always_comb begin
        starting = !wr_en_n && !in_cell_q && wr_soc;
        active   = !wr_en_n && (in_cell_q || wr_soc);
        base     = starting ? '0 : cnt_q;
        remain   = CNT_W'(CELL_BYTES) - base;
        step     = (mode == BUS_WIDE && remain >= CNT_W'(2)) ? CNT_W'(2) : CNT_W'(1);
        next_cnt = base + step;
        lw.vld   = !active ? 2'b00 : (step == CNT_W'(2) ? 2'b11 : 2'b01);
        lw.bytes = {(step == CNT_W'(2)) ? wr_data[15:8] : 8'h00, wr_data[7:0]};
        lw.last  = active && (next_cnt == CNT_W'(CELL_BYTES));
    end

    // Keep the open-cell flag and the byte count of the open cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cell_q <= 1'b0;
            cnt_q     <= '0;
        end else if (active) begin
            in_cell_q <= !lw.last;
            cnt_q     <= lw.last ? '0 : next_cnt;
        end
    end

endmodule

// File: rtl/cif_byte_store.sv
// Module: cif_byte_store
// Circular byte store. Bytes of the open cell are written speculatively
// and become readable only when the cell completes. A byte that finds no
// room is dropped; the rest of that cell is then skipped and rewound at
// its end, and a sticky overflow flag is set.
// Assumes at most two bytes arrive per cycle and one byte leaves.
module cif_byte_store
    import cif_pkg::*;
#(
    parameter int unsigned CELL_BYTES = 53,
    parameter int unsigned DEPTH      = 106,
    parameter int unsigned FREE_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lane_write_t       lw,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              rd_sop,
    output logic [FREE_W-1:0] free_bytes,
    output logic              overflow
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned OFF_W = $clog2(CELL_BYTES);

    logic [7:0]        mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, commit_ptr_q, rd_ptr_q;
    logic [FREE_W-1:0] avail_q, spec_q;
    logic [OFF_W-1:0]  rd_off_q;
    logic              cell_bad_q, overflow_q;

    logic              want0, want1, put0, put1, drop;
    logic              commit, abort, pop;
    logic [1:0]        nput;
    logic [PTR_W-1:0]  wr_addr1, wr_next;

    // Advance a pointer by up to two places around the ring.
    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p, input logic [1:0] n);
        logic [PTR_W:0] t;
        t = {1'b0, p} + (PTR_W+1)'(n);
        if (t >= (PTR_W+1)'(DEPTH)) t = t - (PTR_W+1)'(DEPTH);
        return t[PTR_W-1:0];
    endfunction

    // Space check, write admission and cell commit/abort decisions.
    always_comb begin
        free_bytes = FREE_W'(DEPTH) - avail_q - spec_q;
        want0      = lw.vld[0] && !cell_bad_q;
        want1      = lw.vld[1] && !cell_bad_q;
        put0       = want0 && (free_bytes >= FREE_W'(1));
        put1       = want1 && put0 && (free_bytes >= FREE_W'(2));
        drop       = (want0 && !put0) || (want1 && !put1);
        nput       = {1'b0, put0} + {1'b0, put1};
        commit     = lw.last && !(cell_bad_q || drop);
        abort      = lw.last && (cell_bad_q || drop);
        pop        = rd_valid && rd_ready;
        wr_addr1   = adv(wr_ptr_q, 2'd1);
        wr_next    = adv(wr_ptr_q, nput);
    end

    // Present the oldest committed byte and its first-of-cell marker.
    always_comb begin
        rd_valid = (avail_q != '0);
        rd_data  = mem[rd_ptr_q];
        rd_sop   = rd_valid && (rd_off_q == '0);
        overflow = overflow_q;
    end

    // Byte storage, written without reset.
    always_ff @(posedge clk) begin
        if (put0) mem[wr_ptr_q] <= lw.bytes[7:0];
        if (put1) mem[wr_addr1] <= lw.bytes[15:8];
    end

    // Pointers, counts and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q     <= '0;
            commit_ptr_q <= '0;
            rd_ptr_q     <= '0;
            avail_q      <= '0;
            spec_q       <= '0;
            rd_off_q     <= '0;
            cell_bad_q   <= 1'b0;
            overflow_q   <= 1'b0;
        end else begin
            wr_ptr_q     <= abort ? commit_ptr_q : wr_next;
            commit_ptr_q <= commit ? wr_next : commit_ptr_q;
            spec_q       <= lw.last ? '0 : spec_q + FREE_W'(nput);
            avail_q      <= avail_q - FREE_W'(pop) + (commit ? spec_q + FREE_W'(nput) : '0);
            cell_bad_q   <= lw.last ? 1'b0 : (cell_bad_q || drop);
            overflow_q   <= overflow_q || drop;
            if (pop) begin
                rd_ptr_q <= adv(rd_ptr_q, 2'd1);
                rd_off_q <= (rd_off_q == OFF_W'(CELL_BYTES - 1)) ? '0 : rd_off_q + OFF_W'(1);
            end
        end
    end

endmodule

// File: rtl/cif_space_monitor.sv
// Module: cif_space_monitor
// Drives the cell-available flag with hysteresis: it is set when a full
// cell fits and cleared when only HEADROOM write cycles of room remain.
// Assumes free_bytes is a registered count from the byte store.
module cif_space_monitor
    import cif_pkg::*;
#(
    parameter int unsigned CELL_BYTES = 53,
    parameter int unsigned HEADROOM   = 4,
    parameter int unsigned FREE_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_mode_e         mode,
    input  logic [FREE_W-1:0] free_bytes,
    output logic              cell_avail
);
    logic [FREE_W-1:0] low_mark;

    // Low threshold in bytes for the latched bus width.
    always_comb begin
        low_mark = (mode == BUS_WIDE) ? FREE_W'(2 * HEADROOM) : FREE_W'(HEADROOM);
    end

    // Hysteresis register for the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cell_avail <= 1'b0;
        else if (free_bytes >= FREE_W'(CELL_BYTES))   cell_avail <= 1'b1;
        else if (free_bytes <= low_mark)              cell_avail <= 1'b0;
    end

endmodule

// File: rtl/cell_ingress_fifo.sv
// Module: cell_ingress_fifo (top)
// Accepts cells on a write bus, buffers whole cells and hands them out
// byte by byte on a valid/ready handshake.
// Assumes wide_mode is stable while rst_n is low.
module cell_ingress_fifo
    import cif_pkg::*;
#(
    parameter int unsigned CELL_BYTES      = 53,
    parameter int unsigned CELLS           = 2,
    parameter int unsigned HEADROOM_WRITES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wide_mode,
    input  logic        wr_en_n,
    input  logic [15:0] wr_data,
    input  logic        wr_soc,
    output logic        cell_avail,
    output logic        overflow,
    input  logic        rd_ready,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        rd_sop
);
    localparam int unsigned DEPTH  = CELLS * CELL_BYTES;
    localparam int unsigned FREE_W = $clog2(DEPTH + 1);

    bus_mode_e         mode_q;
    logic              wide_sel;
    lane_write_t       lw;
    logic [FREE_W-1:0] free_bytes;

    // Latch the bus width only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= wide_mode ? BUS_WIDE : BUS_NARROW;
    end

    assign wide_sel = (mode_q == BUS_WIDE);

    cif_cell_assembler #(.CELL_BYTES(CELL_BYTES)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_q),
        .wr_en_n (wr_en_n),
        .wr_data (wr_data),
        .wr_soc  (wr_soc),
        .lw      (lw)
    );

    cif_byte_store #(
        .CELL_BYTES (CELL_BYTES),
        .DEPTH      (DEPTH),
        .FREE_W     (FREE_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lw         (lw),
        .rd_ready   (rd_ready),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_sop     (rd_sop),
        .free_bytes (free_bytes),
        .overflow   (overflow)
    );

    cif_space_monitor #(
        .CELL_BYTES (CELL_BYTES),
        .HEADROOM   (HEADROOM_WRITES),
        .FREE_W     (FREE_W)
    ) u_space (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .free_bytes (free_bytes),
        .cell_avail (cell_avail)
    );

endmodule

// File: rtl/cif_checker.sv
// Module: cif_checker
// Temporal checks on the cell ingress buffer, attached by bind.
module cif_checker #(
    parameter int unsigned CELL_BYTES = 53,
    parameter int unsigned HEADROOM   = 4,
    parameter int unsigned FREE_W     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wide_sel,
    input logic [FREE_W-1:0] free_bytes,
    input logic              cell_avail,
    input logic              overflow,
    input logic              rd_ready,
    input logic              rd_valid,
    input logic [7:0]        rd_data,
    input logic              rd_sop
);
    logic [FREE_W-1:0] low_mark;
    assign low_mark = wide_sel ? FREE_W'(2 * HEADROOM) : FREE_W'(HEADROOM);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !cell_avail && !overflow));

    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_sop)));

    // R7
    avail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_bytes >= FREE_W'(CELL_BYTES)) |=> cell_avail);

    // R8
    avail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_bytes <= low_mark) |=> !cell_avail);

    // R8
    avail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_bytes > low_mark && free_bytes < FREE_W'(CELL_BYTES) && $past(rst_n))
        |=> (cell_avail == $past(cell_avail)));

endmodule

bind cell_ingress_fifo cif_checker #(
    .CELL_BYTES (CELL_BYTES),
    .HEADROOM   (HEADROOM_WRITES),
    .FREE_W     (FREE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide_sel   (wide_sel),
    .free_bytes (free_bytes),
    .cell_avail (cell_avail),
    .overflow   (overflow),
    .rd_ready   (rd_ready),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_sop     (rd_sop)
);

// File: tb/test_cell_ingress_fifo.sv
// Bench for cell_ingress_fifo: directed corner cases plus seeded random
// traffic, compared each cycle against a behavioural model.
module test_cell_ingress_fifo;
    localparam int CB    = 53;
    localparam int DEPTH = 106;
    localparam int HR    = 4;

    logic        clk = 1'b0;
    logic        rst_n, wide_mode, wr_en_n, wr_soc, rd_ready;
    logic [15:0] wr_data;
    logic        cell_avail, overflow, rd_valid, rd_sop;
    logic [7:0]  rd_data;

    always #10 clk = ~clk;

    cell_ingress_fifo i_cell_ingress_fifo (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .wr_en_n(wr_en_n),
        .wr_data(wr_data), .wr_soc(wr_soc), .cell_avail(cell_avail),
        .overflow(overflow), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_sop(rd_sop)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc_cnt = 0;
    string tag = "R10";

    // Model state
    bit        m_wide, m_in, m_bad, m_ovf, m_cav;
    int        m_cnt, m_off;
    bit [7:0]  specq[$];
    bit [7:0]  availq[$];

    task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic compare_outputs();
        chk({tag, " R6"}, "rd_valid", 16'(rd_valid), 16'(availq.size() > 0));
        if (availq.size() > 0) begin
            chk({tag, " R6 R1 R5"}, "rd_data", 16'(rd_data), 16'(availq[0]));
            chk({tag, " R6"}, "rd_sop", 16'(rd_sop), 16'(m_off == 0));
        end
        chk({tag, " R7 R8"}, "cell_avail", 16'(cell_avail), 16'(m_cav));
        chk({tag, " R9"}, "overflow", 16'(overflow), 16'(m_ovf));
    endtask

    // Effect of one rising edge with the given inputs.
    task automatic model_step(bit wen_n, logic [15:0] d, bit soc, bit rdy);
        int  free = DEPTH - availq.size() - specq.size();
        int  thr  = m_wide ? 2 * HR : HR;
        bit  pop  = (availq.size() > 0) && rdy;
        int  n = 0;
        bit  last = 0, drop = 0, put0 = 0, put1 = 0;
        if (free >= CB) m_cav = 1;
        else if (free <= thr) m_cav = 0;
        if (!wen_n) begin
            if (!m_in && soc) begin m_in = 1; m_cnt = 0; end
            if (m_in) begin
                n    = (m_wide && (CB - m_cnt) >= 2) ? 2 : 1;
                last = (m_cnt + n == CB);
            end
        end
        if (n >= 1 && !m_bad) begin
            put0 = (free >= 1);
            if (!put0) drop = 1;
            if (n == 2) begin
                put1 = put0 && (free >= 2);
                if (!put1) drop = 1;
            end
        end
        if (put0) specq.push_back(d[7:0]);
        if (put1) specq.push_back(d[15:8]);
        if (pop) begin
            void'(availq.pop_front());
            m_off = (m_off == CB - 1) ? 0 : m_off + 1;
        end
        if (n > 0) begin
            if (last) begin
                if (!(m_bad || drop)) foreach (specq[k]) availq.push_back(specq[k]);
                specq.delete();
                m_bad = 0; m_in = 0; m_cnt = 0;
            end else begin
                m_bad = m_bad || drop;
                m_cnt = m_cnt + n;
            end
        end
        m_ovf = m_ovf || drop;
    endtask

    task automatic cyc(bit wen_n, logic [15:0] d, bit soc, bit rdy);
        @(negedge clk);
        compare_outputs();
        wr_en_n  = wen_n;
        wr_data  = d;
        wr_soc   = soc;
        rd_ready = rdy;
        model_step(wen_n, d, soc, rdy);
    endtask

    task automatic do_reset(bit wide);
        @(negedge clk);
        rst_n = 1'b0; wide_mode = wide;
        wr_en_n = 1'b1; wr_data = '0; wr_soc = 1'b0; rd_ready = 1'b0;
        repeat (3) @(negedge clk);
        tag = "R10";
        chk("R10", "rd_valid in reset", 16'(rd_valid), 16'd0);
        chk("R10", "cell_avail in reset", 16'(cell_avail), 16'd0);
        chk("R10", "overflow in reset", 16'(overflow), 16'd0);
        m_wide = wide; m_in = 0; m_bad = 0; m_ovf = 0; m_cav = 0;
        m_cnt = 0; m_off = 0; specq.delete(); availq.delete();
        rst_n = 1'b1;
        model_step(1'b1, '0, 1'b0, 1'b0);
    endtask

    // One cell with an optional stray start marker and idle gaps.
    task automatic send_cell(int seed, int stray_at, bit rdy);
        int writes = m_wide ? 27 : 53;
        for (int i = 0; i < writes; i++) begin
            logic [15:0] d;
            if (m_wide) d = {8'(seed + 2 * i + 1), 8'(seed + 2 * i)};
            else        d = {8'hA5 ^ 8'(i), 8'(seed + i)};
            cyc(1'b0, d, (i == 0) || (i == stray_at), rdy);
            if (i % 7 == 3) cyc(1'b1, 16'($urandom), 1'b1, rdy);
        end
    endtask

    task automatic run_mode(bit wide);
        do_reset(wide);
        tag = "R2 R3";
        for (int i = 0; i < 3; i++) cyc(1'b0, 16'($urandom), 1'b0, 1'b0);
        cyc(1'b1, 16'hFFFF, 1'b1, 1'b0);
        tag = "R4";
        send_cell(8'h10, 9, 1'b0);
        tag = "R11";
        send_cell(8'h40, -1, 1'b0);
        cyc(1'b1, '0, 1'b0, 1'b0);
        cyc(1'b1, '0, 1'b0, 1'b0);
        chk("R11", "overflow after two cells", 16'(overflow), 16'd0);
        chk("R8", "cell_avail with store full", 16'(cell_avail), 16'd0);
        chk("R6", "rd_sop on stalled first byte", 16'(rd_sop), 16'd1);
        tag = "R9";
        send_cell(8'h70, -1, 1'b0);
        cyc(1'b1, '0, 1'b0, 1'b0);
        chk("R9", "overflow after third cell", 16'(overflow), 16'd1);
        tag = "R6 R7";
        for (int i = 0; i < 2 * CB + 6; i++) cyc(1'b1, '0, 1'b0, 1'b1);
        chk("R7", "cell_avail after drain", 16'(cell_avail), 16'd1);
        chk("R9", "aborted cell not presented", 16'(rd_valid), 16'd0);
        tag = "R1 random";
        for (int i = 0; i < 3000; i++) begin
            bit stall = ((i / 250) % 3) == 1;
            if ($urandom % 60 == 0) wide_mode = ~wide_mode;
            cyc(($urandom % 10) < 3, 16'($urandom), ($urandom % 24) == 0,
                stall ? 1'b0 : (($urandom % 8) < 5));
        end
        tag = "R6 drain";
        for (int i = 0; i < 2 * CB + 6; i++) cyc(1'b1, '0, 1'b0, 1'b1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc_cnt);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; wide_mode = 1'b0; wr_en_n = 1'b1;
        wr_data = '0; wr_soc = 1'b0; rd_ready = 1'b0;
        run_mode(1'b0);
        run_mode(1'b1);
        @(negedge clk);
        compare_outputs();
        summary();
        $finish;
    end

endmodule